// File: doc/BRIEF.md
# Self-Triggered Front-End Hit Buffer

This block sits beside one readout chip of a high-granularity calorimeter. No external trigger decides what is kept. During a bunch train it looks at every channel on every bunch-crossing strobe. Each channel's digitised amplitude is compared with a programmable threshold. Only channels that pass are stored. Each stored hit is tagged with the channel's pad number and the index of the crossing in which it occurred.

The hits stay in a local buffer for the whole train. Once the train is over, a readout path shared with other chips pulls them out one word per request, oldest first. The buffer has a fixed depth. Hits that arrive when it is full are dropped, and a sticky flag records the loss. The flag stays set until the next train begins.

Crossing strobes must be at least NCH+1 clock cycles apart. This gives the block time to write every passing channel of one crossing before the next crossing is captured.

Top module: `hit_buffer`

## Requirements
- R1: A train-start pulse empties the buffer, clears the overflow flag and sets the crossing index to 0. The first crossing after the start is tagged 0.
- R2: Each crossing strobe inside a train advances the 12-bit crossing index by one. The index stops at 4095 and never wraps. Later crossings in the same train are all tagged 4095.
- R3: A channel is stored only when its amplitude is strictly greater than the threshold. An amplitude equal to the threshold is not stored.
- R4: A hit word is 30 bits wide. Bits 29:18 hold the crossing index, bits 17:12 the pad number and bits 11:0 the amplitude.
- R5: Passing channels of one crossing are written in ascending pad order, one per clock. Hits of later crossings follow those of earlier ones, and readout returns hits in the order they were written.
- R6: The buffer holds DEPTH hits. Hits beyond that are dropped and set the overflow flag. The flag stays set, even after the buffer is drained, until the next train start.
- R7: While a train is running, a read request produces no valid output and removes nothing from the buffer.
- R8: Outside a train, a read request made while hits are stored gives hit_valid high in the next cycle, with the oldest stored hit on hit_word. A request when the buffer is empty gives no valid output.
- R9: The empty flag is high exactly when no hits are held. It is high after reset and after the last hit has been read.
- R10: Crossing strobes outside a train are ignored. Nothing is stored and the crossing index does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_start | input | 1 | One-cycle pulse that begins a bunch train |
| train_stop | input | 1 | One-cycle pulse that ends the bunch train |
| bx_strobe | input | 1 | One-cycle pulse for each bunch crossing |
| samples | input | NCH*12 | Channel amplitudes; channel c occupies bits 12c+11:12c |
| threshold | input | 12 | A channel passes when its amplitude is greater than this value |
| rd_req | input | 1 | Read request from the shared readout path |
| hit_word | output | 30 | Read hit: {crossing[11:0], pad[5:0], amplitude[11:0]} |
| hit_valid | output | 1 | hit_word carries a read hit in this cycle |
| overflow | output | 1 | Sticky flag: at least one hit was dropped in this train |
| empty | output | 1 | No hits are held |

## Verification
On every cycle, the assertions check the following:
- a train start leaves the buffer empty, the overflow flag clear and the crossing index at zero;
- a saturated index stays saturated;
- pads of one crossing are written in ascending order;
- the overflow flag never falls inside a train;
- the fill level never exceeds the depth;
- no valid output appears while a train runs or without a request.

Only the bench scenarios can show the following:
- the strict comparison against the threshold, including amplitudes equal to it;
- the exact field layout and content of each word;
- first-in first-out order across crossings;
- that exactly DEPTH hits survive an overflow;
- that strobes outside a train leave no trace.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int BXW  = 12;
  localparam int PADW = 6;
  localparam int AMPW = 12;

  typedef struct packed {
    logic [BXW-1:0]  bx;
    logic [PADW-1:0] pad;
    logic [AMPW-1:0] amp;
  } hit_t;

  localparam int HW = $bits(hit_t);
endpackage

// File: rtl/hb_scan.sv
// Captures one crossing and emits its passing channels, lowest pad first.
module hb_scan
  import hb_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                capture,
  input  logic [NCH*AMPW-1:0] samples,
  input  logic [AMPW-1:0]     threshold,
  input  logic [BXW-1:0]      bx_in,
  output logic                pend_valid,
  output hit_t                pend_hit
);
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]  mask;
  logic [AMPW-1:0] amp_q [NCH];
  logic [BXW-1:0]  bx_q;
  logic [SW-1:0]   sel;

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (mask[i]) sel = SW'(i);
  end

  assign pend_valid   = |mask;
  assign pend_hit.bx  = bx_q;
  assign pend_hit.pad = PADW'(sel);
  assign pend_hit.amp = amp_q[sel];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_q;

    always_ff @(posedge clk) begin
      if (rst || flush)
        hit_q <= 1'b0;
      else if (capture)
        hit_q <= samples[g*AMPW +: AMPW] > threshold;
      else if (pend_valid && sel == SW'(g))
        hit_q <= 1'b0;
    end

    always_ff @(posedge clk)
      if (capture) amp_q[g] <= samples[g*AMPW +: AMPW];

    assign mask[g] = hit_q;
  end

  always_ff @(posedge clk)
    if (capture) bx_q <= bx_in;
endmodule

// File: rtl/hb_mem.sv
// Simple dual-port store with registered read.
module hb_mem #(
  parameter int DEPTH = 32,
  parameter int W     = 30,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hit_buffer.sv
module hit_buffer
  import hb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                train_start,
  input  logic                train_stop,
  input  logic                bx_strobe,
  input  logic [NCH*AMPW-1:0] samples,
  input  logic [AMPW-1:0]     threshold,
  input  logic                rd_req,
  output logic [HW-1:0]       hit_word,
  output logic                hit_valid,
  output logic                overflow,
  output logic                empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [BXW-1:0] BX_MAX = '1;

  logic           in_train;
  logic [BXW-1:0] bx_cnt;
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  count;
  logic           ovf_q, valid_q;
  logic           capture, we, re, pend_valid;
  hit_t           pend_hit;

  assign capture = bx_strobe && in_train && !train_start;
  assign we      = pend_valid && (count != CW'(DEPTH));
  assign re      = rd_req && !in_train && !train_start && !pend_valid && (count != '0);

  hb_scan #(.NCH(NCH)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .flush     (train_start),
    .capture   (capture),
    .samples   (samples),
    .threshold (threshold),
    .bx_in     (bx_cnt),
    .pend_valid(pend_valid),
    .pend_hit  (pend_hit)
  );

  hb_mem #(.DEPTH(DEPTH), .W(HW)) u_mem (
    .clk  (clk),
    .we   (we),
    .waddr(wp),
    .wdata(pend_hit),
    .re   (re),
    .raddr(rp),
    .rdata(hit_word)
  );

  always_ff @(posedge clk) begin
    if (rst)              in_train <= 1'b0;
    else if (train_start) in_train <= 1'b1;
    else if (train_stop)  in_train <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || train_start)              bx_cnt <= '0;
    else if (capture && bx_cnt != BX_MAX) bx_cnt <= bx_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || train_start) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (we) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (re) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(we) - CW'(re);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || train_start)                     ovf_q <= 1'b0;
    else if (pend_valid && count == CW'(DEPTH)) ovf_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= re;
  end

  assign hit_valid = valid_q;
  assign overflow  = ovf_q;
  assign empty     = (count == '0);
endmodule

// File: rtl/hb_chk.sv
module hb_chk
  import hb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            train_start,
  input logic            rd_req,
  input logic            in_train,
  input logic            hit_valid,
  input logic            overflow,
  input logic            empty,
  input logic [CW-1:0]   count,
  input logic [BXW-1:0]  bx_cnt,
  input logic            we,
  input logic [PADW-1:0] wr_pad,
  input logic [BXW-1:0]  wr_bx
);
  localparam logic [BXW-1:0] BX_TOP = '1;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    train_start |=> (empty && !overflow && bx_cnt == '0)); // R1

  AST_BX_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (bx_cnt == BX_TOP && !train_start) |=> (bx_cnt == BX_TOP)); // R2

  AST_PAD_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (we && $past(we) && wr_bx == $past(wr_bx)) |-> (wr_pad > $past(wr_pad))); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow && !train_start) |=> overflow); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R6

  AST_QUIET_IN_TRAIN: assert property (@(posedge clk) disable iff (rst)
    in_train |=> !hit_valid); // R7

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $past(rd_req)); // R8
endmodule

bind hit_buffer hb_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .train_start(train_start),
  .rd_req     (rd_req),
  .in_train   (in_train),
  .hit_valid  (hit_valid),
  .overflow   (overflow),
  .empty      (empty),
  .count      (count),
  .bx_cnt     (bx_cnt),
  .we         (we),
  .wr_pad     (pend_hit.pad),
  .wr_bx      (pend_hit.bx)
);

// File: tb/tb_hit_buffer.sv
module tb_hit_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int DEPTH = 32;
  localparam int AMPW  = 12;
  localparam logic [AMPW-1:0] THR = 12'd100;
  localparam int NVEC = 6;

  // one crossing per entry, amplitudes {ch7 .. ch0}
  localparam logic [NCH*AMPW-1:0] VEC [NVEC] = '{
    {12'd0,   12'd0,   12'd0,   12'd0,   12'd0,   12'd0,   12'd0,   12'd0},
    {12'd4095,12'd0,   12'd0,   12'd0,   12'd100, 12'd0,   12'd0,   12'd101},
    {12'd207, 12'd206, 12'd205, 12'd204, 12'd203, 12'd202, 12'd201, 12'd200},
    {12'd0,   12'd150, 12'd99,  12'd0,   12'd0,   12'd0,   12'd0,   12'd0},
    {12'd0,   12'd0,   12'd0,   12'd0,   12'd0,   12'd0,   12'd100, 12'd0},
    {12'd0,   12'd0,   12'd0,   12'd101, 12'd0,   12'd500, 12'd0,   12'd0}
  };

  logic clk = 1'b0;
  logic rst, train_start, train_stop, bx_strobe, rd_req;
  logic [NCH*AMPW-1:0] samples;
  logic [AMPW-1:0] threshold;
  logic [29:0] hit_word;
  logic hit_valid, overflow, empty;

  int checks = 0;
  int failures = 0;
  logic [29:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_buffer #(.NCH(NCH), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .train_start(train_start), .train_stop(train_stop),
    .bx_strobe(bx_strobe), .samples(samples), .threshold(threshold),
    .rd_req(rd_req), .hit_word(hit_word), .hit_valid(hit_valid),
    .overflow(overflow), .empty(empty)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    train_start = 1'b1; ticks(1); train_start = 1'b0;
  endtask

  task automatic pulse_stop();
    train_stop = 1'b1; ticks(1); train_stop = 1'b0;
  endtask

  // strobe one crossing, then leave room for all writes
  task automatic crossing(input logic [NCH*AMPW-1:0] v, input int gap);
    samples = v; bx_strobe = 1'b1; ticks(1);
    bx_strobe = 1'b0; samples = '0; ticks(gap);
  endtask

  task automatic model(input logic [NCH*AMPW-1:0] v, input int bx);
    for (int c = 0; c < NCH; c++) begin
      logic [AMPW-1:0] a;
      a = v[c*AMPW +: AMPW];
      if (a > THR) exp_q.push_back({12'(bx), 6'(c), a});
    end
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (!empty && guard < 2*DEPTH) begin
      logic [29:0] e;
      guard++;
      rd_req = 1'b1; ticks(1); rd_req = 1'b0;
      if (exp_q.size() == 0) begin
        chk(1'b0, {req, " extra hit"}, {2'b0, hit_word}, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(hit_valid && hit_word == e, req, {1'b0, hit_valid, hit_word}, {2'b01, e});
      end
    end
    chk(exp_q.size() == 0, {req, " missing hits"}, 32'(exp_q.size()), 32'h0);
    chk(empty == 1'b1, "R9 empty after drain", {31'b0, empty}, 32'h1);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; train_start = 1'b0; train_stop = 1'b0; bx_strobe = 1'b0;
    rd_req = 1'b0; samples = '0; threshold = THR;
    ticks(3);
    rst = 1'b0;
    ticks(1);

    // reset state
    chk(empty == 1'b1, "R9 empty after reset", {31'b0, empty}, 32'h1);
    chk(overflow == 1'b0, "R6 overflow clear after reset", {31'b0, overflow}, 32'h0);
    chk(hit_valid == 1'b0, "R8 no valid after reset", {31'b0, hit_valid}, 32'h0);

    // R10: crossing outside a train is ignored
    crossing({NCH{12'd900}}, 12);
    chk(empty == 1'b1, "R10 strobe outside train stores nothing", {31'b0, empty}, 32'h1);
    rd_req = 1'b1; ticks(1); rd_req = 1'b0;
    chk(hit_valid == 1'b0, "R8 read when empty gives no valid", {31'b0, hit_valid}, 32'h0);

    // main table: R1 R2 R3 R4 R5
    pulse_start();
    for (int i = 0; i < NVEC; i++) begin
      crossing(VEC[i], 12);
      model(VEC[i], i);
    end
    chk(empty == 1'b0, "R9 not empty with hits", {31'b0, empty}, 32'h0);
    // R7: read during train is ignored
    rd_req = 1'b1; ticks(1); rd_req = 1'b0;
    chk(hit_valid == 1'b0, "R7 no valid during train", {31'b0, hit_valid}, 32'h0);
    pulse_stop();
    crossing({NCH{12'd900}}, 12); // R10 after stop: must not be stored
    drain("R3 R4 R5 R7 R10 table readout");

    // overflow train: 5 crossings x 8 hits = 40 > DEPTH
    pulse_start();
    chk(overflow == 1'b0, "R1 overflow cleared by start", {31'b0, overflow}, 32'h0);
    for (int i = 0; i < 5; i++) begin
      logic [NCH*AMPW-1:0] v;
      for (int c = 0; c < NCH; c++) v[c*AMPW +: AMPW] = 12'(300 + 8*i + c);
      crossing(v, 12);
      if (i < 4) model(v, i);
    end
    chk(overflow == 1'b1, "R6 overflow set when full", {31'b0, overflow}, 32'h1);
    pulse_stop();
    drain("R6 first DEPTH hits kept");
    chk(overflow == 1'b1, "R6 overflow sticky after drain", {31'b0, overflow}, 32'h1);

    // R1 start clears overflow and buffer; R2 saturation
    pulse_start();
    chk(overflow == 1'b0, "R1 overflow cleared", {31'b0, overflow}, 32'h0);
    chk(empty == 1'b1, "R1 buffer cleared", {31'b0, empty}, 32'h1);
    begin
      logic [NCH*AMPW-1:0] v;
      v = '0; v[1*AMPW +: AMPW] = 12'd150;
      crossing(v, 12); model(v, 0);
      for (int k = 1; k < 4100; k++) crossing('0, 1);
      v = '0; v[3*AMPW +: AMPW] = 12'd300;
      crossing(v, 12); model(v, 4095);
      v = '0; v[0*AMPW +: AMPW] = 12'd301;
      crossing(v, 12); model(v, 4095);
    end
    pulse_stop();
    drain("R2 index starts at 0 and saturates at 4095");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule